// File: doc/BRIEF.md
# Multicast and VLAN Receive Filter

This block decides, for every received frame, whether it is kept or dropped on the strength of its destination address and its VLAN ID. It holds two small content-addressable tables: one of 48-bit group addresses and one of VLAN IDs. Each table has its own 32-bit enable mask, and an entry whose mask bit is clear never matches. A 64-bin hash filter can replace the address table. A promiscuous setting overrides every filter.

Software reaches both tables through one byte-wide register port. It opens an access sequence through the control register and picks a table with a select bit. It then loads an entry index and stages the entry in an eight-byte data window. A write strobe commits the entry, and a read strobe copies an entry back into the window. On the receive side an upstream parser presents the destination address, a tag flag and the VID for one cycle. The verdict appears on registered outputs one clock later.

Register addresses: window bytes 0x00-0x07, mask bytes 0x08-0x0B (bits 7:0 at 0x08), control 0x0C, entry index 0x0D, configuration 0x0E, hash vector bytes 0x10-0x17 (bins 8k..8k+7 at 0x10+k). Control bits: bit0 access enable, bit1 VLAN table select, bit2 write strobe, bit3 read strobe. Configuration bits: bit0 VLAN filtering, bit1 promiscuous, bit2 hash mode.

Top module: `mcvlan_filter`

## Requirements
- R1: After reset the masks, the control, index and configuration registers, the window and the hash vector all read zero, and no address entry matches.
- R2: An entry is written only by a control write that has the access enable (bit0) and the write strobe (bit2) set together; a strobe without the enable leaves the tables unchanged.
- R3: Only the low 5 bits of the index register are kept, so an index of 0x23 addresses entry 3 and reads back as 0x03.
- R4: An address entry is staged as six bytes at window offsets 0..5, offset 0 holding the first address byte on the wire; a VLAN entry is staged as a 16-bit value, low byte at offset 6 and high byte at offset 7.
- R5: A mask byte write with access enabled updates the mask of the table picked by the select bit, and the mask bytes read back that table's mask; without the enable the write is ignored; an entry with its mask bit clear never matches.
- R6: A frame whose destination has the group bit (bit 0 of the first byte) clear passes address filtering. In table mode a group frame passes only when an enabled entry equals the whole 48-bit address, and that match is reported as the address hit.
- R7: In hash mode the bin is the top 6 bits of the CRC-32 of the destination address (polynomial 0x04C11DB7, preset all ones, each byte fed low bit first, no final inversion). A group frame passes when its bin's bit is set, so an all-ones vector accepts every group frame.
- R8: With VLAN filtering on, a tagged frame passes only when an enabled VLAN entry's low 12 bits equal its VID; an untagged frame always passes; with filtering off the VID has no effect on acceptance.
- R9: Writing the configuration with promiscuous set stores VLAN filtering as off, and every frame is then accepted.
- R10: A control write with enable and read strobe copies the indexed entry of the selected table into its window bytes by the next cycle, leaving the other window bytes as they were.
- R11: The result is valid exactly one cycle after a frame is presented, and valid is low in other cycles.
- R12: Writing 0 to the control register ends the access sequence and keeps the table contents, the masks and the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 8 | Register write address |
| reg_wdata | input | 8 | Register write data |
| reg_raddr | input | 8 | Register read address |
| reg_rdata | output | 8 | Register read data (combinational) |
| frm_valid | input | 1 | Frame header present this cycle |
| frm_da | input | 48 | Destination address, first wire byte in bits 47:40 |
| frm_tagged | input | 1 | Frame carries a VLAN tag |
| frm_vid | input | 12 | VLAN ID of a tagged frame |
| res_valid | output | 1 | Result valid |
| res_accept | output | 1 | Frame is kept |
| res_mc_hit | output | 1 | Group address matched a table entry or a hash bin |
| res_vlan_hit | output | 1 | Tagged frame matched an enabled VLAN entry |

## Verification
The hardest situations to reach are those where the two tables and the shared staging window interfere. Examples are a strobe issued without the enable, an index above 31 that aliases onto a live entry, and a read strobe that must refill only the bytes of its own table. Directed sequences build each of these. A seeded random phase then interleaves entry loads at wrapped indices, mask rewrites and configuration changes with frames. About half of those frames reuse a stored address or VID, so hits, aliasing and masked-off entries all occur many times.

// File: rtl/mcvlan_pkg.sv
// Shared constants and helpers for the multicast/VLAN receive filter.
// Assumes a byte-wide register port with the fixed address map below.
package mcvlan_pkg;
    localparam logic [7:0] A_WIN0  = 8'h00;
    localparam logic [7:0] A_MASK0 = 8'h08;
    localparam logic [7:0] A_CTRL  = 8'h0C;
    localparam logic [7:0] A_INDEX = 8'h0D;
    localparam logic [7:0] A_CFG   = 8'h0E;
    localparam logic [7:0] A_HASH0 = 8'h10;
    localparam int MASK_W   = 32;
    localparam int HASH_W   = 64;
    localparam int ADDR_W   = 48;
    localparam int VTAB_W   = 16;
    localparam int VID_W    = 12;
    localparam logic [31:0] CRC_POLY = 32'h04C11DB7;

    // Control register layout, bit3 down to bit0.
    typedef struct packed {
        logic rd;
        logic wr;
        logic vsel;
        logic en;
    } ctrl_t;

    // Configuration register layout, bit2 down to bit0.
    typedef struct packed {
        logic hash;
        logic promisc;
        logic vlan_on;
    } cfg_t;

    // Top six bits of the CRC-32 of an address, bytes in wire order, low bit first.
    function automatic logic [5:0] hash_bin(input logic [ADDR_W-1:0] da);
        logic [31:0] c;
        logic        fb;
        c = '1;
        for (int b = 0; b < ADDR_W / 8; b++) begin
            for (int i = 0; i < 8; i++) begin
                fb = c[31] ^ da[ADDR_W - 8 - 8 * b + i];
                c  = {c[30:0], 1'b0};
                if (fb) c = c ^ CRC_POLY;
            end
        end
        return c[31:26];
    endfunction
endpackage

// File: rtl/mcvlan_regs.sv
// Register file of the filter: staging window, index, control, masks,
// configuration and hash vector. Produces one-cycle write pulses toward the
// two tables and refills the window on a read strobe.
// Assumes one register write per cycle and ENTRIES <= 32 (power of two).
module mcvlan_regs
    import mcvlan_pkg::*;
#(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [7:0]           reg_addr,
    input  logic [7:0]           reg_wdata,
    input  logic [7:0]           reg_raddr,
    output logic [7:0]           reg_rdata,
    input  logic [ADDR_W-1:0]    mc_rd,
    input  logic [VTAB_W-1:0]    vl_rd,
    output logic                 mc_we,
    output logic                 vl_we,
    output logic [IDX_W-1:0]     idx,
    output logic [ADDR_W-1:0]    mc_stage,
    output logic [VTAB_W-1:0]    vl_stage,
    output logic [MASK_W-1:0]    mc_mask,
    output logic [MASK_W-1:0]    vl_mask,
    output cfg_t                 cfg,
    output logic [HASH_W-1:0]    hash_vec,
    output ctrl_t                ctrl
);
    localparam int WIN_N  = 8;
    localparam int MC_BYT = ADDR_W / 8;

    logic [7:0] win [WIN_N];
    ctrl_t      wctl;
    logic       ctrl_wr;
    logic       rd_go;
    logic       mask_wr;
    logic       win_wr;
    logic       hash_wr;

    assign wctl    = ctrl_t'(reg_wdata[3:0]);
    assign ctrl_wr = reg_we && (reg_addr == A_CTRL);
    assign mc_we   = ctrl_wr && wctl.en && wctl.wr && !wctl.vsel;
    assign vl_we   = ctrl_wr && wctl.en && wctl.wr && wctl.vsel;
    assign rd_go   = ctrl_wr && wctl.en && wctl.rd;
    assign mask_wr = reg_we && (reg_addr[7:2] == A_MASK0[7:2]) && ctrl.en;
    assign win_wr  = reg_we && (reg_addr[7:3] == A_WIN0[7:3]);
    assign hash_wr = reg_we && (reg_addr[7:3] == A_HASH0[7:3]);

    // Staged entries are views of the window bytes.
    generate
        for (genvar k = 0; k < MC_BYT; k++) begin : g_mcst
            assign mc_stage[ADDR_W-1-8*k -: 8] = win[k];
        end
    endgenerate
    assign vl_stage = {win[7], win[6]};

    // Window: byte writes from software, bulk refill on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < WIN_N; k++) win[k] <= '0;
        end else if (rd_go) begin
            if (wctl.vsel) begin
                win[6] <= vl_rd[7:0];
                win[7] <= vl_rd[15:8];
            end else begin
                for (int k = 0; k < MC_BYT; k++) win[k] <= mc_rd[ADDR_W-1-8*k -: 8];
            end
        end else if (win_wr) begin
            win[reg_addr[2:0]] <= reg_wdata;
        end
    end

    // Control and index registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
            idx  <= '0;
        end else if (ctrl_wr) begin
            ctrl <= wctl;
        end else if (reg_we && reg_addr == A_INDEX) begin
            idx <= reg_wdata[IDX_W-1:0];
        end
    end

    // Per-table enable masks, byte-wise, only while access is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mc_mask <= '0;
            vl_mask <= '0;
        end else if (mask_wr) begin
            if (ctrl.vsel) vl_mask[8*int'(reg_addr[1:0]) +: 8] <= reg_wdata;
            else           mc_mask[8*int'(reg_addr[1:0]) +: 8] <= reg_wdata;
        end
    end

    // Configuration; promiscuous forces VLAN filtering off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (reg_we && reg_addr == A_CFG) begin
            cfg.hash    <= reg_wdata[2];
            cfg.promisc <= reg_wdata[1];
            cfg.vlan_on <= reg_wdata[0] && !reg_wdata[1];
        end
    end

    // Hash vector bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hash_vec <= '0;
        end else if (hash_wr) begin
            hash_vec[8*int'(reg_addr[2:0]) +: 8] <= reg_wdata;
        end
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        if (reg_raddr[7:3] == A_WIN0[7:3])
            reg_rdata = win[reg_raddr[2:0]];
        else if (reg_raddr[7:2] == A_MASK0[7:2])
            reg_rdata = ctrl.vsel ? vl_mask[8*int'(reg_raddr[1:0]) +: 8]
                                  : mc_mask[8*int'(reg_raddr[1:0]) +: 8];
        else if (reg_raddr == A_CTRL)
            reg_rdata = {4'b0, ctrl};
        else if (reg_raddr == A_INDEX)
            reg_rdata = 8'(idx);
        else if (reg_raddr == A_CFG)
            reg_rdata = {5'b0, cfg};
        else if (reg_raddr[7:3] == A_HASH0[7:3])
            reg_rdata = hash_vec[8*int'(reg_raddr[2:0]) +: 8];
    end
endmodule

// File: rtl/mcvlan_table.sv
// One content-addressable table: ENTRIES words of W bits with one write port,
// one indexed read port and a parallel compare of the low CMP_W bits against
// a key. Assumes the enable mask is supplied by the register file.
module mcvlan_table #(
    parameter int ENTRIES = 32,
    parameter int W       = 48,
    parameter int CMP_W   = 48
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [$clog2(ENTRIES)-1:0] widx,
    input  logic [W-1:0]               wdata,
    input  logic [$clog2(ENTRIES)-1:0] ridx,
    output logic [W-1:0]               rdata,
    input  logic [ENTRIES-1:0]         en_mask,
    input  logic [CMP_W-1:0]           key,
    output logic                       hit
);
    logic [W-1:0]       ent [ENTRIES];
    logic [ENTRIES-1:0] match;

    // Entry storage, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < ENTRIES; k++) ent[k] <= '0;
        end else if (we) begin
            ent[widx] <= wdata;
        end
    end

    // Per-entry compare gated by the entry's enable bit.
    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
            assign match[g] = en_mask[g] && (ent[g][CMP_W-1:0] == key);
        end
    endgenerate

    assign hit   = |match;
    assign rdata = ent[ridx];
endmodule

// File: rtl/mcvlan_decide.sv
// Combines address and VLAN results into a registered verdict.
// Assumes table hits are combinational from the same frame inputs.
module mcvlan_decide
    import mcvlan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_valid,
    input  logic [ADDR_W-1:0] frm_da,
    input  logic              frm_tagged,
    input  logic              mc_cam_hit,
    input  logic              vl_cam_hit,
    input  cfg_t              cfg,
    input  logic [HASH_W-1:0] hash_vec,
    output logic              res_valid,
    output logic              res_accept,
    output logic              res_mc_hit,
    output logic              res_vlan_hit
);
    logic       is_grp;
    logic [5:0] bin;
    logic       mc_hit;
    logic       vl_hit;
    logic       addr_ok;
    logic       vlan_ok;
    logic       accept;

    // Address and VLAN decision for the frame on the inputs.
    always_comb begin
        is_grp  = frm_da[ADDR_W-8];
        bin     = hash_bin(frm_da);
        mc_hit  = is_grp && (cfg.hash ? hash_vec[bin] : mc_cam_hit);
        vl_hit  = frm_tagged && vl_cam_hit;
        addr_ok = !is_grp || mc_hit;
        vlan_ok = !cfg.vlan_on || !frm_tagged || vl_cam_hit;
        accept  = cfg.promisc || (addr_ok && vlan_ok);
    end

    // Result register, one cycle after the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid    <= 1'b0;
            res_accept   <= 1'b0;
            res_mc_hit   <= 1'b0;
            res_vlan_hit <= 1'b0;
        end else begin
            res_valid    <= frm_valid;
            res_accept   <= frm_valid && accept;
            res_mc_hit   <= frm_valid && mc_hit;
            res_vlan_hit <= frm_valid && vl_hit;
        end
    end
endmodule

// File: rtl/mcvlan_filter.sv
// Multicast address and VLAN ID receive filter: register file, two tables
// and the decision stage. Assumes frame fields are parsed upstream.
module mcvlan_filter
    import mcvlan_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    input  logic [7:0]  reg_raddr,
    output logic [7:0]  reg_rdata,
    input  logic        frm_valid,
    input  logic [47:0] frm_da,
    input  logic        frm_tagged,
    input  logic [11:0] frm_vid,
    output logic        res_valid,
    output logic        res_accept,
    output logic        res_mc_hit,
    output logic        res_vlan_hit
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic              mc_we;
    logic              vl_we;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] mc_stage;
    logic [VTAB_W-1:0] vl_stage;
    logic [MASK_W-1:0] mc_mask;
    logic [MASK_W-1:0] vl_mask;
    cfg_t              cfg;
    ctrl_t             ctrl;
    logic [HASH_W-1:0] hash_vec;
    logic [ADDR_W-1:0] mc_rd;
    logic [VTAB_W-1:0] vl_rd;
    logic              mc_cam_hit;
    logic              vl_cam_hit;

    mcvlan_regs #(.ENTRIES(ENTRIES)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .mc_rd(mc_rd), .vl_rd(vl_rd), .mc_we(mc_we), .vl_we(vl_we), .idx(idx),
        .mc_stage(mc_stage), .vl_stage(vl_stage), .mc_mask(mc_mask),
        .vl_mask(vl_mask), .cfg(cfg), .hash_vec(hash_vec), .ctrl(ctrl)
    );

    mcvlan_table #(.ENTRIES(ENTRIES), .W(ADDR_W), .CMP_W(ADDR_W)) u_mctab (
        .clk(clk), .rst_n(rst_n), .we(mc_we), .widx(idx), .wdata(mc_stage),
        .ridx(idx), .rdata(mc_rd), .en_mask(mc_mask[ENTRIES-1:0]),
        .key(frm_da), .hit(mc_cam_hit)
    );

    mcvlan_table #(.ENTRIES(ENTRIES), .W(VTAB_W), .CMP_W(VID_W)) u_vltab (
        .clk(clk), .rst_n(rst_n), .we(vl_we), .widx(idx), .wdata(vl_stage),
        .ridx(idx), .rdata(vl_rd), .en_mask(vl_mask[ENTRIES-1:0]),
        .key(frm_vid), .hit(vl_cam_hit)
    );

    mcvlan_decide u_decide (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_da(frm_da),
        .frm_tagged(frm_tagged), .mc_cam_hit(mc_cam_hit), .vl_cam_hit(vl_cam_hit),
        .cfg(cfg), .hash_vec(hash_vec), .res_valid(res_valid),
        .res_accept(res_accept), .res_mc_hit(res_mc_hit), .res_vlan_hit(res_vlan_hit)
    );
endmodule

// Property checker for the filter, bound to every instance of the top.
module mcvlan_filter_chk
    import mcvlan_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [7:0]        reg_addr,
    input logic [7:0]        reg_wdata,
    input logic              frm_valid,
    input logic [47:0]       frm_da,
    input logic              res_valid,
    input logic              res_accept,
    input logic              res_mc_hit,
    input logic [MASK_W-1:0] mc_mask,
    input logic [MASK_W-1:0] vl_mask,
    input cfg_t              cfg,
    input ctrl_t             ctrl
);
    p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> res_valid);
    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid |=> !res_valid);
    p_promisc_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && cfg.promisc) |=> res_accept);
    p_promisc_vlan_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.promisc |-> !cfg.vlan_on);
    p_unicast_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !frm_da[40] && !cfg.vlan_on) |=> res_accept);
    p_unicast_nohit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !frm_da[40]) |=> !res_mc_hit);
    p_empty_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && mc_mask == '0 && !cfg.hash) |=> !res_mc_hit);
    p_mask_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr[7:2] == A_MASK0[7:2] && !ctrl.en) |=>
        ($stable(mc_mask) && $stable(vl_mask)));
    p_ctrl_zero_keeps_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_CTRL && reg_wdata == 8'h00) |=>
        ($stable(mc_mask) && $stable(vl_mask)));
endmodule

bind mcvlan_filter mcvlan_filter_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .frm_valid(frm_valid), .frm_da(frm_da),
    .res_valid(res_valid), .res_accept(res_accept), .res_mc_hit(res_mc_hit),
    .mc_mask(mc_mask), .vl_mask(vl_mask), .cfg(cfg), .ctrl(ctrl)
);

// File: tb/mcvlan_filter_tb.sv
module mcvlan_filter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0, reg_wdata = '0, reg_raddr = '0;
    logic [7:0]  reg_rdata;
    logic        frm_valid = 1'b0, frm_tagged = 1'b0;
    logic [47:0] frm_da = '0;
    logic [11:0] frm_vid = '0;
    logic        res_valid, res_accept, res_mc_hit, res_vlan_hit;

    int n_cmp = 0;
    int n_bad = 0;

    logic [47:0] m_mc [32];
    logic [15:0] m_vl [32];
    logic [31:0] m_mmask = '0, m_vmask = '0;
    logic [2:0]  m_cfg = '0;
    logic [63:0] m_hash = '0;

    always #5 clk = ~clk;

    mcvlan_filter u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .frm_valid(frm_valid), .frm_da(frm_da), .frm_tagged(frm_tagged),
        .frm_vid(frm_vid), .res_valid(res_valid), .res_accept(res_accept),
        .res_mc_hit(res_mc_hit), .res_vlan_hit(res_vlan_hit)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Bench CRC: bytes shifted out of a copy, low bit first.
    function automatic logic [5:0] ref_bin(input logic [47:0] da);
        logic [31:0] c = 32'hFFFF_FFFF;
        logic [47:0] d = da;
        for (int b = 0; b < 6; b++) begin
            logic [7:0] by = d[47:40];
            d = d << 8;
            for (int i = 0; i < 8; i++) begin
                logic top = c[31];
                c = c << 1;
                if (top != by[0]) c = c ^ 32'h04C11DB7;
                by = by >> 1;
            end
        end
        return c[31:26];
    endfunction

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_raddr = a;
        #1 v = reg_rdata;
    endtask

    task automatic load_mc(input logic [7:0] ix, input logic [47:0] da);
        wr(8'h0C, 8'h01); wr(8'h0D, ix);
        for (int k = 0; k < 6; k++) wr(8'(k), da[47-8*k -: 8]);
        wr(8'h0C, 8'h05); wr(8'h0C, 8'h00);
        m_mc[ix[4:0]] = da;
    endtask

    task automatic load_vl(input logic [7:0] ix, input logic [15:0] v);
        wr(8'h0C, 8'h03); wr(8'h0D, ix);
        wr(8'h06, v[7:0]); wr(8'h07, v[15:8]);
        wr(8'h0C, 8'h07); wr(8'h0C, 8'h00);
        m_vl[ix[4:0]] = v;
    endtask

    task automatic set_mask(input bit vsel, input logic [31:0] m);
        wr(8'h0C, vsel ? 8'h03 : 8'h01);
        for (int k = 0; k < 4; k++) wr(8'h08 + 8'(k), m[8*k +: 8]);
        wr(8'h0C, 8'h00);
        if (vsel) m_vmask = m; else m_mmask = m;
    endtask

    task automatic set_cfg(input logic [7:0] d);
        wr(8'h0E, d);
        m_cfg = {d[2], d[1], d[0] & ~d[1]};
    endtask

    task automatic set_hash(input logic [63:0] h);
        for (int k = 0; k < 8; k++) wr(8'h10 + 8'(k), h[8*k +: 8]);
        m_hash = h;
    endtask

    // Expected verdict from the requirements.
    task automatic predict(input logic [47:0] da, input bit tg, input logic [11:0] vid,
                           output bit acc, output bit mh, output bit vh);
        bit grp = da[40];
        mh = 1'b0; vh = 1'b0;
        if (grp) begin
            if (m_cfg[2]) mh = m_hash[ref_bin(da)];
            else for (int i = 0; i < 32; i++) if (m_mmask[i] && m_mc[i] == da) mh = 1'b1;
        end
        if (tg) for (int i = 0; i < 32; i++) if (m_vmask[i] && m_vl[i][11:0] == vid) vh = 1'b1;
        acc = m_cfg[1] || ((!grp || mh) && (!m_cfg[0] || !tg || vh));
    endtask

    task automatic frame(input logic [47:0] da, input bit tg, input logic [11:0] vid, input string req);
        bit ea, em, ev;
        predict(da, tg, vid, ea, em, ev);
        @(negedge clk);
        frm_valid = 1'b1; frm_da = da; frm_tagged = tg; frm_vid = vid;
        @(negedge clk);
        frm_valid = 1'b0;
        chk(res_valid == 1'b1, {req, " R11 valid"}, 64'(res_valid), 64'd1);
        chk(res_accept == ea, {req, " accept"}, 64'(res_accept), 64'(ea));
        chk(res_mc_hit == em, {req, " mc_hit"}, 64'(res_mc_hit), 64'(em));
        chk(res_vlan_hit == ev, {req, " vlan_hit"}, 64'(res_vlan_hit), 64'(ev));
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0]  v;
        logic [47:0] ma, mb, mcc, md, me;
        int          s;
        s = $urandom(32'd4021);
        for (int i = 0; i < 32; i++) begin m_mc[i] = '0; m_vl[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 24; a++) begin
            if (a == 8'h0F) continue;
            rd(8'(a), v);
            chk(v == 8'h00, $sformatf("R1 reg %0h", a), 64'(v), 64'd0);
        end
        ma = 48'h01_00_5E_12_34_56;
        frame(ma, 1'b0, 12'h0, "R1 empty table");

        // R4, R6: program entry 3 and enable it
        load_mc(8'd3, ma);
        set_mask(1'b0, 32'h0000_0008);
        frame(ma, 1'b0, 12'h0, "R6 hit");
        frame(48'h00_11_22_33_44_55, 1'b0, 12'h0, "R6 unicast");
        frame(ma ^ 48'h1, 1'b0, 12'h0, "R6 near miss");

        // R2: strobe without enable leaves entry 3
        mb = 48'h33_33_00_00_00_01;
        wr(8'h0D, 8'd3);
        for (int k = 0; k < 6; k++) wr(8'(k), mb[47-8*k -: 8]);
        wr(8'h0C, 8'h04); wr(8'h0C, 8'h00);
        frame(ma, 1'b0, 12'h0, "R2 old kept");
        frame(mb, 1'b0, 12'h0, "R2 no write");

        // R10, R4: read strobe refills window bytes 0..5 only
        wr(8'h06, 8'hA5);
        wr(8'h0C, 8'h09);
        for (int k = 0; k < 6; k++) begin
            rd(8'(k), v);
            chk(v == ma[47-8*k -: 8], "R10 readback", 64'(v), 64'(ma[47-8*k -: 8]));
        end
        rd(8'h06, v);
        chk(v == 8'hA5, "R10 other byte kept", 64'(v), 64'hA5);
        wr(8'h0C, 8'h00);

        // R3: index wraps modulo 32
        mcc = 48'h01_80_C2_00_00_0E;
        load_mc(8'h23, mcc);
        rd(8'h0D, v);
        chk(v == 8'h03, "R3 index", 64'(v), 64'h03);
        frame(mcc, 1'b0, 12'h0, "R3 alias hit");
        frame(ma, 1'b0, 12'h0, "R3 replaced");

        // R5: mask write ignored without enable, then cleared
        wr(8'h08, 8'h00);
        rd(8'h08, v);
        chk(v == 8'h08, "R5 mask ignored", 64'(v), 64'h08);
        frame(mcc, 1'b0, 12'h0, "R5 still hit");
        set_mask(1'b0, 32'h0);
        frame(mcc, 1'b0, 12'h0, "R5 masked off");

        // R8: VLAN filtering with high bits ignored
        load_vl(8'd0, 16'hF064);
        set_mask(1'b1, 32'h1);
        frame(48'h00_11_22_33_44_55, 1'b1, 12'h065, "R8 off no effect");
        set_cfg(8'h01);
        frame(48'h00_11_22_33_44_55, 1'b1, 12'h064, "R8 vid hit");
        frame(48'h00_11_22_33_44_55, 1'b1, 12'h065, "R8 vid miss");
        frame(48'h00_11_22_33_44_55, 1'b0, 12'h065, "R8 untagged");

        // R9: promiscuous wins, VLAN bit stored off
        set_cfg(8'h03);
        rd(8'h0E, v);
        chk(v == 8'h02, "R9 cfg", 64'(v), 64'h02);
        frame(48'h01_02_03_04_05_06, 1'b1, 12'h065, "R9 accept all");

        // R7: hash mode
        set_cfg(8'h04);
        md = 48'h01_00_5E_00_00_FB;
        frame(md, 1'b0, 12'h0, "R7 empty hash");
        set_hash(64'd1 << ref_bin(md));
        frame(md, 1'b0, 12'h0, "R7 bin hit");
        me = md;
        while (ref_bin(me) == ref_bin(md)) me = me + 48'h100;
        frame(me, 1'b0, 12'h0, "R7 other bin");
        set_hash('1);
        frame(me, 1'b0, 12'h0, "R7 all ones");

        // R12: control zero keeps masks and window
        set_cfg(8'h00);
        wr(8'h0C, 8'h03); wr(8'h0C, 8'h00);
        rd(8'h08, v);
        chk(v == 8'h00, "R12 mc mask", 64'(v), 64'h00);
        rd(8'h06, v);
        chk(v == 8'h64, "R12 window", 64'(v), 64'h64);
        frame(48'h00_00_00_00_00_01, 1'b1, 12'h064, "R12 vlan entry kept");
        @(negedge clk);
        chk(res_valid == 1'b0, "R11 valid drops", 64'(res_valid), 64'd0);

        // Random phase
        for (int it = 0; it < 400; it++) begin
            int op = $urandom_range(0, 9);
            if (op == 0) load_mc(8'($urandom), {$urandom_range(0,1) == 1 ? 8'h01 : 8'h03, 40'($urandom_range(0, 7))});
            else if (op == 1) load_vl(8'($urandom), 16'($urandom));
            else if (op == 2) set_mask($urandom_range(0,1) == 1, $urandom);
            else if (op == 3) set_cfg(8'($urandom_range(0, 7)));
            else if (op == 4) set_hash({$urandom, $urandom});
            else begin
                logic [47:0] da;
                logic [11:0] vid;
                da  = ($urandom_range(0,1) == 1) ? m_mc[$urandom_range(0,31)]
                                                 : {8'($urandom), 40'($urandom_range(0, 7))};
                vid = ($urandom_range(0,1) == 1) ? m_vl[$urandom_range(0,31)][11:0] : 12'($urandom);
                frame(da, $urandom_range(0,1) == 1, vid, "R6 R7 R8 random");
            end
        end
        finish_run();
    end
endmodule